// File: doc/BRIEF.md
# Break Exception Timing Sequencer

This block sits between the break comparators and the exception logic of a processor core. Each comparator channel reports a one-cycle match pulse together with a kind. The kind says whether the match is a fetch match taken before the instruction executes, a fetch match taken after it executes, or an operand (data) access match. The sequencer also watches instruction retire events. Each retire event carries the address of the instruction that follows, plus a flag saying the retired instruction blocks interrupt acceptance at the boundary after it.

The sequencer decides when the break exception is requested and which program counter value goes with it.

- A pre-execution match at an interrupt-accepting point is raised at once, with the matched fetch address.
- Every other match becomes a pending break, held in a register. It is raised at the first retire boundary that accepts interrupts, with the address of the next instruction.
- Matches that arrive while a break is pending are folded into it. The single request that results reports every channel involved.

Top module: `brk_exc_seq`

## Requirements
- R1: After synchronous reset, `brk_req` is 0. No break is pending, and the interrupt-inhibit state is clear.
- R2: A pre-execution match (kind 2'b00) in a cycle where nothing is pending and the inhibit state is clear raises `brk_req` in the next cycle. In that cycle `brk_pc` equals `match_pc` of the match cycle and `brk_chan` equals the match mask.
- R3: A pre-execution match while the inhibit state is set becomes pending. It raises `brk_req` one cycle after the first retire with `ret_nointr`=0, and `brk_pc` is that retire's `ret_next`.
- R4: A post-execution match (kind 2'b01) never raises at once. It raises `brk_req` one cycle after the next retire with `ret_nointr`=0, and `brk_pc` is that retire's `ret_next`.
- R5: A retire with `ret_nointr`=1 sets the inhibit state and never fires a pending break. It also sets up the deferral of a pre-execution match that follows it. A retire with `ret_nointr`=0 clears the inhibit state.
- R6: A data-access match (kind 2'b10, with 2'b11 treated the same way) is deferred like R4. `brk_pc` is the `ret_next` of the first accepting retire.
- R7: A pending break is raised exactly once, and the pending state is cleared when it is raised. Later retires give no request until a new match arrives.
- R8: Matches that arrive while a break is pending, or in the cycle it fires, are merged into it. One request is raised, and its `brk_chan` is the OR of all merged channel masks.
- R9: `brk_req` is high for single cycles only for each break, and `brk_chan` is non-zero whenever `brk_req` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| match_vld | input | NCH | Per-channel match pulse |
| match_kind | input | 2*NCH | Per-channel kind, 2 bits per channel, channel c at bits [2c+1:2c] |
| match_pc | input | AW | Fetch address of the matched instruction (pre-execution case) |
| ret_vld | input | 1 | An instruction retires this cycle |
| ret_nointr | input | 1 | The retiring instruction blocks interrupts at the boundary after it |
| ret_next | input | AW | Address of the instruction after the retiring one |
| brk_req | output | 1 | Break exception request pulse |
| brk_pc | output | AW | Program counter value to save |
| brk_chan | output | NCH | Mask of the channels that caused the break |

## Verification
The assertions assume that match pulses and retire events are sampled in the same cycle as the comparator and retire logic produce them. They also assume that a match arriving in the same cycle as a retire belongs to an instruction that has not yet retired. The stimulus drives every input at the falling edge and holds it for exactly one cycle. Retires and matches go in separate cycles, except in the merge case, where the cycle-sharing rule of R8 is what is being tested.

// File: rtl/brk_seq_pkg.sv
package brk_seq_pkg;
  typedef enum logic [1:0] {
    BK_PRE  = 2'b00,
    BK_POST = 2'b01,
    BK_DATA = 2'b10,
    BK_DATX = 2'b11
  } brk_kind_e;
endpackage

// File: rtl/brk_inh_track.sv
module brk_inh_track (
  input  logic clk,
  input  logic rst,
  input  logic ret_vld,
  input  logic ret_nointr,
  output logic inh_q
);
  always_ff @(posedge clk) begin
    if (rst)          inh_q <= 1'b0;
    else if (ret_vld) inh_q <= ret_nointr;
  end
endmodule

// File: rtl/brk_match_decode.sv
module brk_match_decode
  import brk_seq_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic [NCH-1:0]   match_vld,
  input  logic [2*NCH-1:0] match_kind,
  output logic             pre_hit,
  output logic             any_hit
);
  logic [NCH-1:0] pre_vec;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign pre_vec[c] = match_vld[c] &&
                        (brk_kind_e'(match_kind[2*c +: 2]) == BK_PRE);
  end

  assign pre_hit = |pre_vec;
  assign any_hit = |match_vld;
endmodule

// File: rtl/brk_pend_reg.sv
module brk_pend_reg #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           fire,
  input  logic           any_hit,
  input  logic [NCH-1:0] chan_in,
  output logic           pend_q,
  output logic [NCH-1:0] pend_chan_q
);
  always_ff @(posedge clk) begin
    if (rst || fire) begin
      pend_q      <= 1'b0;
      pend_chan_q <= '0;
    end else if (any_hit) begin
      pend_q      <= 1'b1;
      pend_chan_q <= pend_chan_q | chan_in;
    end
  end
endmodule

// File: rtl/brk_out_reg.sv
module brk_out_reg #(
  parameter int NCH = 2,
  parameter int AW  = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           fire,
  input  logic [AW-1:0]  fire_pc,
  input  logic [NCH-1:0] fire_chan,
  output logic           brk_req,
  output logic [AW-1:0]  brk_pc,
  output logic [NCH-1:0] brk_chan
);
  always_ff @(posedge clk) begin
    if (rst) begin
      brk_req  <= 1'b0;
      brk_pc   <= '0;
      brk_chan <= '0;
    end else begin
      brk_req <= fire;
      if (fire) begin
        brk_pc   <= fire_pc;
        brk_chan <= fire_chan;
      end
    end
  end
endmodule

// File: rtl/brk_exc_seq.sv
module brk_exc_seq #(
  parameter int NCH = 2,
  parameter int AW  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   match_vld,
  input  logic [2*NCH-1:0] match_kind,
  input  logic [AW-1:0]    match_pc,
  input  logic             ret_vld,
  input  logic             ret_nointr,
  input  logic [AW-1:0]    ret_next,
  output logic             brk_req,
  output logic [AW-1:0]    brk_pc,
  output logic [NCH-1:0]   brk_chan
);
  logic           inh_q;
  logic           pre_hit;
  logic           any_hit;
  logic           pend_q;
  logic [NCH-1:0] pend_chan_q;
  logic           fire_ret;
  logic           fire_imm;
  logic           fire;
  logic [AW-1:0]  fire_pc;
  logic [NCH-1:0] fire_chan;

  brk_inh_track u_inh (
    .clk        (clk),
    .rst        (rst),
    .ret_vld    (ret_vld),
    .ret_nointr (ret_nointr),
    .inh_q      (inh_q)
  );

  brk_match_decode #(.NCH(NCH)) u_dec (
    .match_vld  (match_vld),
    .match_kind (match_kind),
    .pre_hit    (pre_hit),
    .any_hit    (any_hit)
  );

  // Deferred break leaves at an accepting boundary; a fresh pre-execution
  // match leaves at once when nothing blocks it.
  assign fire_ret  = pend_q && ret_vld && !ret_nointr;
  assign fire_imm  = pre_hit && !inh_q && !pend_q;
  assign fire      = fire_ret || fire_imm;
  assign fire_pc   = fire_ret ? ret_next : match_pc;
  assign fire_chan = pend_chan_q | match_vld;

  brk_pend_reg #(.NCH(NCH)) u_pend (
    .clk         (clk),
    .rst         (rst),
    .fire        (fire),
    .any_hit     (any_hit),
    .chan_in     (match_vld),
    .pend_q      (pend_q),
    .pend_chan_q (pend_chan_q)
  );

  brk_out_reg #(.NCH(NCH), .AW(AW)) u_out (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire),
    .fire_pc   (fire_pc),
    .fire_chan (fire_chan),
    .brk_req   (brk_req),
    .brk_pc    (brk_pc),
    .brk_chan  (brk_chan)
  );
endmodule

// File: rtl/brk_exc_seq_chk.sv
module brk_exc_seq_chk #(
  parameter int NCH = 2,
  parameter int AW  = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           pre_hit,
  input logic           inh_q,
  input logic           pend_q,
  input logic [AW-1:0]  match_pc,
  input logic           ret_vld,
  input logic           ret_nointr,
  input logic [AW-1:0]  ret_next,
  input logic           brk_req,
  input logic [AW-1:0]  brk_pc,
  input logic [NCH-1:0] brk_chan
);
  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> !brk_req && !pend_q && !inh_q);

  assert_immediate_pre_R2: assert property (@(posedge clk) disable iff (rst)
    (pre_hit && !inh_q && !pend_q) |=> brk_req && brk_pc == $past(match_pc));

  assert_deferred_pc_R3: assert property (@(posedge clk) disable iff (rst)
    (pend_q && ret_vld && !ret_nointr) |=> brk_req && brk_pc == $past(ret_next));

  assert_hold_while_inhibited_R5: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !(ret_vld && !ret_nointr)) |=> !brk_req && pend_q);

  assert_clear_on_raise_R7: assert property (@(posedge clk) disable iff (rst)
    brk_req |-> !pend_q);

  assert_chan_nonzero_R9: assert property (@(posedge clk) disable iff (rst)
    brk_req |-> brk_chan != '0);
endmodule

bind brk_exc_seq brk_exc_seq_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pre_hit    (pre_hit),
  .inh_q      (inh_q),
  .pend_q     (pend_q),
  .match_pc   (match_pc),
  .ret_vld    (ret_vld),
  .ret_nointr (ret_nointr),
  .ret_next   (ret_next),
  .brk_req    (brk_req),
  .brk_pc     (brk_pc),
  .brk_chan   (brk_chan)
);

// File: tb/brk_exc_seq_tb_top.sv
module brk_exc_seq_tb_top;
  localparam int NCH = 2;
  localparam int AW  = 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NCH-1:0]   match_vld = '0;
  logic [2*NCH-1:0] match_kind = '0;
  logic [AW-1:0]    match_pc = '0;
  logic             ret_vld = 1'b0;
  logic             ret_nointr = 1'b0;
  logic [AW-1:0]    ret_next = '0;
  logic             brk_req;
  logic [AW-1:0]    brk_pc;
  logic [NCH-1:0]   brk_chan;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  brk_exc_seq #(.NCH(NCH), .AW(AW)) dut_i (
    .clk(clk), .rst(rst), .match_vld(match_vld), .match_kind(match_kind),
    .match_pc(match_pc), .ret_vld(ret_vld), .ret_nointr(ret_nointr),
    .ret_next(ret_next), .brk_req(brk_req), .brk_pc(brk_pc), .brk_chan(brk_chan)
  );

  task automatic check(input bit exp_req, input logic [AW-1:0] exp_pc,
                       input logic [NCH-1:0] exp_chan, input string req);
    n_chk++;
    if (brk_req !== exp_req) begin
      n_fail++;
      $display("FAIL %s brk_req actual %0b expected %0b", req, brk_req, exp_req);
    end else if (exp_req && (brk_pc !== exp_pc || brk_chan !== exp_chan)) begin
      n_fail++;
      $display("FAIL %s pc/chan actual %h/%b expected %h/%b",
               req, brk_pc, brk_chan, exp_pc, exp_chan);
    end
  endtask

  // One-cycle stimulus, launched at a falling edge; outputs sampled at the next.
  task automatic cyc(input logic [NCH-1:0] v, input logic [2*NCH-1:0] k,
                     input logic [AW-1:0] mpc, input bit rv, input bit rn,
                     input logic [AW-1:0] nx);
    match_vld = v; match_kind = k; match_pc = mpc;
    ret_vld = rv; ret_nointr = rn; ret_next = nx;
    @(negedge clk);
    match_vld = '0; match_kind = '0; ret_vld = 1'b0; ret_nointr = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a_pc, n_pc;
    logic [NCH-1:0] cm;
    logic [2*NCH-1:0] km;
    bit imm;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(1'b0, '0, '0, "R1");
    cyc('0, '0, '0, 1'b1, 1'b0, 32'h40);
    check(1'b0, '0, '0, "R1");

    for (int k = 0; k < 4; k++) begin
      for (int ih = 0; ih < 2; ih++) begin
        for (int c = 0; c < NCH; c++) begin
          a_pc = 32'h1000 + 32'(k * 256 + ih * 16 + c * 4);
          n_pc = 32'h8000 + 32'(k * 256 + ih * 16 + c * 4);
          cm   = NCH'(1) << c;
          km   = (2*NCH)'(k) << (2 * c);
          imm  = (k == 0) && (ih == 0);
          cyc('0, '0, '0, 1'b1, 1'(ih), 32'h50);
          check(1'b0, '0, '0, "R5");
          cyc(cm, km, a_pc, 1'b0, 1'b0, '0);
          if (imm) check(1'b1, a_pc, cm, "R2");
          else     check(1'b0, '0, '0, (k == 0) ? "R3" : (k == 1) ? "R4" : "R6");
          cyc('0, '0, '0, 1'b1, 1'b1, 32'h60);
          check(1'b0, '0, '0, "R5");
          cyc('0, '0, '0, 1'b1, 1'b0, n_pc);
          if (imm) check(1'b0, '0, '0, "R7");
          else     check(1'b1, n_pc, cm, (k == 0) ? "R3" : (k == 1) ? "R4" : "R6");
          cyc('0, '0, '0, 1'b1, 1'b0, 32'h70);
          check(1'b0, '0, '0, "R7");
        end
      end
    end

    // R8: post match ch0, data match ch1 while pending, then accept.
    cyc(2'b01, 4'b0001, 32'h2000, 1'b0, 1'b0, '0);
    check(1'b0, '0, '0, "R8");
    cyc(2'b10, 4'b1000, 32'h2004, 1'b0, 1'b0, '0);
    check(1'b0, '0, '0, "R8");
    cyc('0, '0, '0, 1'b1, 1'b0, 32'h9000);
    check(1'b1, 32'h9000, 2'b11, "R8");
    cyc('0, '0, '0, 1'b0, 1'b0, '0);
    check(1'b0, '0, '0, "R9");

    // R8: pre match pending on ch1, new pre match ch0 in firing cycle.
    cyc('0, '0, '0, 1'b1, 1'b1, 32'h80);
    cyc(2'b10, 4'b0000, 32'h3000, 1'b0, 1'b0, '0);
    check(1'b0, '0, '0, "R3");
    cyc(2'b01, 4'b0000, 32'h3100, 1'b1, 1'b0, 32'hA000);
    check(1'b1, 32'hA000, 2'b11, "R8");
    cyc('0, '0, '0, 1'b1, 1'b0, 32'h90);
    check(1'b0, '0, '0, "R7");

    // R1: reset in the middle of a pending break discards it.
    cyc(2'b01, 4'b0001, 32'h4000, 1'b0, 1'b0, '0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(1'b0, '0, '0, "R1");
    cyc('0, '0, '0, 1'b1, 1'b0, 32'hB000);
    check(1'b0, '0, '0, "R1");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule